// File: doc/BRIEF.md
# Banked domain access permission checker

This block stores a 32-bit domain permission word. The word splits sixteen memory domains into 2-bit codes. There is one copy of the word for the secure state and one for the non-secure state. A system-register port reads and writes the copy that matches the requester's security state. Only privileged requesters may use this port. A requester at the lowest level is refused with an error pulse. An external lock input freezes the secure copy against writes.

A lookup port takes a 4-bit domain number from a translation result, the security state of that translation, and a flag that says whether the page-level permissions allow the access. The block reads the code for that domain from the matching copy and reports one of three outcomes one clock later:

- access allowed
- domain fault
- permission fault

When the long-descriptor translation format is selected, the domain codes are not used. The outcome then follows the page-level result alone.

Top module: `dom_perm_unit`

## Requirements
- R1: A synchronous active-high reset clears both copies to zero, so every domain starts as no-access. After reset, a lookup in short format reports a domain fault, and reads of either copy return 0.
- R2: The code for domain n sits in bits [2n+1:2n] of the word, for n from 0 to 15.
- R3: Code 2'b00 (no access) gives a domain fault (res_kind 2'b01).
- R4: Code 2'b01 (client) gives allowed (res_kind 2'b00) when lk_page_ok is 1. It gives a permission fault (res_kind 2'b10) when lk_page_ok is 0.
- R5: Code 2'b11 (manager) gives allowed whatever the value of lk_page_ok.
- R6: The reserved code 2'b10 gives a domain fault.
- R7: Register accesses use the secure copy when reg_sec is 1 and the non-secure copy when it is 0. Lookups select a copy the same way from lk_sec. Writing one copy leaves the other unchanged.
- R8: While sec_lock is 1, writes to the secure copy are silently ignored and raise no error. Writes to the non-secure copy still take effect.
- R9: While long_fmt is 1, a lookup reports allowed if lk_page_ok is 1 and a permission fault if it is 0, whatever the domain code.
- R10: A register access with reg_priv 0 is refused. reg_undef pulses with the response, a refused write leaves the copy unchanged, and a refused read returns 0. Levels 1 to 3 may both read and write.
- R11: reg_rsp_vld, reg_undef and reg_rdata appear one clock after the request. A read in the cycle after a write returns the new value. res_vld and res_kind appear one clock after lk_vld, and res_vld stays low when no lookup was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req_vld | input | 1 | Register access request |
| reg_req_wr | input | 1 | 1 = write, 0 = read |
| reg_priv | input | 2 | Privilege level of requester, 0 = unprivileged |
| reg_sec | input | 1 | Security state of requester, 1 = secure |
| reg_wdata | input | 32 | Write data |
| reg_rsp_vld | output | 1 | Register response valid |
| reg_undef | output | 1 | Refused-access error pulse |
| reg_rdata | output | 32 | Read data, 0 for writes and refusals |
| sec_lock | input | 1 | Freezes the secure copy against writes |
| long_fmt | input | 1 | Long-descriptor format selected, domain check bypassed |
| lk_vld | input | 1 | Lookup request |
| lk_sec | input | 1 | Security state of the translation |
| lk_dom | input | 4 | Domain number |
| lk_page_ok | input | 1 | Page-level permission check passed |
| res_vld | output | 1 | Lookup result valid |
| res_kind | output | 2 | 00 allowed, 01 domain fault, 10 permission fault |

## Verification
The hardest case to reach is a lookup that selects a different copy from the one a register access just used. Both copies must hold different codes for the same domain, and the secure copy must be seen to stay unchanged while locked. The bench first loads the secure copy with all-manager codes and the non-secure copy with a mixed pattern. It then toggles sec_lock and tries writes to each copy, reading both back. Finally it runs lookups of the same domain against each copy, in short and long format.

// File: rtl/dom_perm_pkg.sv
package dom_perm_pkg;

    localparam int CODE_W = 2;
    localparam int PRIV_W = 2;
    localparam int NUM_BANK = 2;
    localparam int BANK_SEC = 1;

    typedef enum logic [CODE_W-1:0] {
        DC_NONE   = 2'b00,
        DC_CLIENT = 2'b01,
        DC_RSVD   = 2'b10,
        DC_MGR    = 2'b11
    } dcode_e;

    typedef enum logic [1:0] {
        RK_ALLOW = 2'b00,
        RK_DOMF  = 2'b01,
        RK_PERMF = 2'b10
    } rkind_e;

    typedef struct packed {
        logic   vld;
        rkind_e kind;
    } lk_res_t;

    function automatic rkind_e judge(input dcode_e code, input logic page_ok,
                                     input logic long_fmt);
        rkind_e r;
        if (long_fmt) begin
            r = page_ok ? RK_ALLOW : RK_PERMF;
        end else begin
            case (code)
                DC_CLIENT: r = page_ok ? RK_ALLOW : RK_PERMF;
                DC_MGR:    r = RK_ALLOW;
                default:   r = RK_DOMF;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dom_perm_bank.sv
module dom_perm_bank
    import dom_perm_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int WORD_W = NUM_DOM * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sec,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sec_lock,
    output logic [WORD_W-1:0] sec_word,
    output logic [WORD_W-1:0] ns_word
);

    logic [WORD_W-1:0] words_q [NUM_BANK];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic hit;
        logic frozen;
        assign hit    = wr_en && (wr_sec == (b == BANK_SEC));
        assign frozen = (b == BANK_SEC) && sec_lock;

        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[b] <= '0;
            end else if (hit && !frozen) begin
                words_q[b] <= wr_data;
            end
        end
    end

    assign sec_word = words_q[BANK_SEC];
    assign ns_word  = words_q[1-BANK_SEC];

endmodule

// File: rtl/dom_perm_eval.sv
module dom_perm_eval
    import dom_perm_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int WORD_W = NUM_DOM * CODE_W,
    localparam int DOM_W  = $clog2(NUM_DOM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_vld,
    input  logic [DOM_W-1:0]  lk_dom,
    input  logic              lk_page_ok,
    input  logic              long_fmt,
    input  logic [WORD_W-1:0] word,
    output lk_res_t           res
);

    dcode_e  code;
    lk_res_t res_d;

    always_comb begin
        code       = dcode_e'(word[lk_dom*CODE_W +: CODE_W]);
        res_d.vld  = lk_vld;
        res_d.kind = lk_vld ? judge(code, lk_page_ok, long_fmt) : RK_ALLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res <= res_d;
        end
    end

endmodule

// File: rtl/dom_perm_unit.sv
module dom_perm_unit
    import dom_perm_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int WORD_W = NUM_DOM * CODE_W,
    localparam int DOM_W  = $clog2(NUM_DOM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req_vld,
    input  logic              reg_req_wr,
    input  logic [PRIV_W-1:0] reg_priv,
    input  logic              reg_sec,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              reg_rsp_vld,
    output logic              reg_undef,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              sec_lock,
    input  logic              long_fmt,
    input  logic              lk_vld,
    input  logic              lk_sec,
    input  logic [DOM_W-1:0]  lk_dom,
    input  logic              lk_page_ok,
    output logic              res_vld,
    output logic [1:0]        res_kind
);

    logic              priv_ok;
    logic              granted;
    logic [WORD_W-1:0] sec_word;
    logic [WORD_W-1:0] ns_word;
    logic [WORD_W-1:0] lk_word;
    lk_res_t           res;

    assign priv_ok = (reg_priv != '0);
    assign granted = reg_req_vld && priv_ok;

    dom_perm_bank #(.NUM_DOM(NUM_DOM)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (granted && reg_req_wr),
        .wr_sec   (reg_sec),
        .wr_data  (reg_wdata),
        .sec_lock (sec_lock),
        .sec_word (sec_word),
        .ns_word  (ns_word)
    );

    assign lk_word = lk_sec ? sec_word : ns_word;

    dom_perm_eval #(.NUM_DOM(NUM_DOM)) u_eval (
        .clk        (clk),
        .rst        (rst),
        .lk_vld     (lk_vld),
        .lk_dom     (lk_dom),
        .lk_page_ok (lk_page_ok),
        .long_fmt   (long_fmt),
        .word       (lk_word),
        .res        (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rsp_vld <= 1'b0;
            reg_undef   <= 1'b0;
            reg_rdata   <= '0;
        end else begin
            reg_rsp_vld <= reg_req_vld;
            reg_undef   <= reg_req_vld && !priv_ok;
            reg_rdata   <= (granted && !reg_req_wr) ? (reg_sec ? sec_word : ns_word) : '0;
        end
    end

    assign res_vld  = res.vld;
    assign res_kind = res.kind;

endmodule

// File: rtl/dom_perm_chk.sv
module dom_perm_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_req_vld,
    input logic              reg_req_wr,
    input logic [1:0]        reg_priv,
    input logic              reg_sec,
    input logic              reg_rsp_vld,
    input logic              reg_undef,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              sec_lock,
    input logic              long_fmt,
    input logic              lk_vld,
    input logic              lk_page_ok,
    input logic              res_vld,
    input logic [1:0]        res_kind,
    input logic [WORD_W-1:0] sec_word,
    input logic [WORD_W-1:0] ns_word
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sec_word == '0) && (ns_word == '0));

    p_lock_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        sec_lock |=> $stable(sec_word));

    p_bypass_ok_r9: assert property (@(posedge clk) disable iff (rst)
        (lk_vld && long_fmt && lk_page_ok) |=> (res_kind == 2'b00));

    p_bypass_bad_r9: assert property (@(posedge clk) disable iff (rst)
        (lk_vld && long_fmt && !lk_page_ok) |=> (res_kind == 2'b10));

    p_refuse_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_req_vld && reg_priv == 2'd0) |=> (reg_undef && reg_rsp_vld && reg_rdata == '0));

    p_refused_write_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_req_vld && reg_req_wr && reg_priv == 2'd0) |=> ($stable(sec_word) && $stable(ns_word)));

    p_other_copy_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_req_vld && reg_req_wr && !reg_sec) |=> $stable(sec_word));

    p_res_timing_r11: assert property (@(posedge clk) disable iff (rst)
        lk_vld |=> res_vld);

    p_res_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !lk_vld |=> !res_vld);

    p_rsp_timing_r11: assert property (@(posedge clk) disable iff (rst)
        reg_req_vld |=> reg_rsp_vld);

    p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_kind != 2'b11));

endmodule

bind dom_perm_unit dom_perm_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_req_vld (reg_req_vld),
    .reg_req_wr  (reg_req_wr),
    .reg_priv    (reg_priv),
    .reg_sec     (reg_sec),
    .reg_rsp_vld (reg_rsp_vld),
    .reg_undef   (reg_undef),
    .reg_rdata   (reg_rdata),
    .sec_lock    (sec_lock),
    .long_fmt    (long_fmt),
    .lk_vld      (lk_vld),
    .lk_page_ok  (lk_page_ok),
    .res_vld     (res_vld),
    .res_kind    (res_kind),
    .sec_word    (sec_word),
    .ns_word     (ns_word)
);

// File: tb/sim_dom_perm_unit.sv
module sim_dom_perm_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req_vld = 1'b0;
    logic        reg_req_wr = 1'b0;
    logic [1:0]  reg_priv = 2'd0;
    logic        reg_sec = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rsp_vld;
    logic        reg_undef;
    logic [31:0] reg_rdata;
    logic        sec_lock = 1'b0;
    logic        long_fmt = 1'b0;
    logic        lk_vld = 1'b0;
    logic        lk_sec = 1'b0;
    logic [3:0]  lk_dom = '0;
    logic        lk_page_ok = 1'b0;
    logic        res_vld;
    logic [1:0]  res_kind;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [1:0] K_OK = 2'b00, K_DOM = 2'b01, K_PERM = 2'b10;

    always #10 clk = ~clk;

    dom_perm_unit u0 (
        .clk(clk), .rst(rst),
        .reg_req_vld(reg_req_vld), .reg_req_wr(reg_req_wr), .reg_priv(reg_priv),
        .reg_sec(reg_sec), .reg_wdata(reg_wdata), .reg_rsp_vld(reg_rsp_vld),
        .reg_undef(reg_undef), .reg_rdata(reg_rdata), .sec_lock(sec_lock),
        .long_fmt(long_fmt), .lk_vld(lk_vld), .lk_sec(lk_sec), .lk_dom(lk_dom),
        .lk_page_ok(lk_page_ok), .res_vld(res_vld), .res_kind(res_kind)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sec, input logic [1:0] priv,
                             input logic [31:0] data, input logic exp_undef, input string tag);
        @(negedge clk);
        reg_req_vld = 1'b1; reg_req_wr = 1'b1; reg_sec = sec; reg_priv = priv; reg_wdata = data;
        @(posedge clk); #1;
        check({tag, " rsp_vld"}, {31'd0, reg_rsp_vld}, 32'd1);
        check({tag, " undef"}, {31'd0, reg_undef}, {31'd0, exp_undef});
        @(negedge clk);
        reg_req_vld = 1'b0; reg_req_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sec, input logic [1:0] priv,
                            input logic [31:0] exp, input logic exp_undef, input string tag);
        @(negedge clk);
        reg_req_vld = 1'b1; reg_req_wr = 1'b0; reg_sec = sec; reg_priv = priv;
        @(posedge clk); #1;
        check({tag, " rdata"}, reg_rdata, exp);
        check({tag, " undef"}, {31'd0, reg_undef}, {31'd0, exp_undef});
        @(negedge clk);
        reg_req_vld = 1'b0;
    endtask

    task automatic lookup(input logic sec, input logic [3:0] dom, input logic pok,
                          input logic lf, input logic [1:0] exp, input string tag);
        @(negedge clk);
        lk_vld = 1'b1; lk_sec = sec; lk_dom = dom; lk_page_ok = pok; long_fmt = lf;
        @(posedge clk); #1;
        check({tag, " res_vld"}, {31'd0, res_vld}, 32'd1);
        check({tag, " res_kind"}, {30'd0, res_kind}, {30'd0, exp});
        @(negedge clk);
        lk_vld = 1'b0;
        @(posedge clk); #1;
        check({tag, " idle R11"}, {31'd0, res_vld}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 rsp idle", {31'd0, reg_rsp_vld}, 32'd0);
        check("R1 res idle", {31'd0, res_vld}, 32'd0);
        reg_read(1'b0, 2'd1, 32'h0, 1'b0, "R1 ns zero");
        reg_read(1'b1, 2'd1, 32'h0, 1'b0, "R1 sec zero");
        lookup(1'b0, 4'd5, 1'b1, 1'b0, K_DOM, "R1 lookup after reset");
    endtask

    task automatic t_codes;
        // dom0=00 dom1=01 dom2=11 dom3=10 dom15=11
        reg_write(1'b0, 2'd1, 32'hC00000B4, 1'b0, "R11 ns write");
        reg_read(1'b0, 2'd1, 32'hC00000B4, 1'b0, "R11 read after write");
        lookup(1'b0, 4'd0, 1'b1, 1'b0, K_DOM, "R3 no access");
        lookup(1'b0, 4'd1, 1'b1, 1'b0, K_OK, "R4 client ok");
        lookup(1'b0, 4'd1, 1'b0, 1'b0, K_PERM, "R4 client denied");
        lookup(1'b0, 4'd2, 1'b0, 1'b0, K_OK, "R5 manager");
        lookup(1'b0, 4'd3, 1'b1, 1'b0, K_DOM, "R6 reserved");
        lookup(1'b0, 4'd15, 1'b0, 1'b0, K_OK, "R2 top field");
        lookup(1'b0, 4'd14, 1'b1, 1'b0, K_DOM, "R2 dom14");
    endtask

    task automatic t_bank;
        reg_write(1'b1, 2'd3, 32'hFFFFFFFF, 1'b0, "R7 sec write");
        reg_read(1'b0, 2'd1, 32'hC00000B4, 1'b0, "R7 ns kept");
        reg_read(1'b1, 2'd3, 32'hFFFFFFFF, 1'b0, "R7 sec read");
        lookup(1'b1, 4'd0, 1'b0, 1'b0, K_OK, "R7 sec lookup");
        lookup(1'b0, 4'd0, 1'b0, 1'b0, K_DOM, "R7 ns lookup");
    endtask

    task automatic t_lock;
        @(negedge clk); sec_lock = 1'b1;
        reg_write(1'b1, 2'd2, 32'h0, 1'b0, "R8 locked write");
        reg_read(1'b1, 2'd2, 32'hFFFFFFFF, 1'b0, "R8 sec frozen");
        reg_write(1'b0, 2'd2, 32'h55555555, 1'b0, "R8 ns write");
        reg_read(1'b0, 2'd2, 32'h55555555, 1'b0, "R8 ns updated");
        @(negedge clk); sec_lock = 1'b0;
        reg_write(1'b1, 2'd2, 32'h0000000C, 1'b0, "R8 unlocked write");
        reg_read(1'b1, 2'd2, 32'h0000000C, 1'b0, "R8 sec updated");
    endtask

    task automatic t_priv;
        reg_write(1'b0, 2'd0, 32'h0, 1'b1, "R10 refused write");
        reg_read(1'b0, 2'd1, 32'h55555555, 1'b0, "R10 value kept");
        reg_read(1'b0, 2'd0, 32'h0, 1'b1, "R10 refused read");
        reg_read(1'b0, 2'd2, 32'h55555555, 1'b0, "R10 level2 read");
        @(posedge clk); #1;
        check("R10 undef pulse ends", {31'd0, reg_undef}, 32'd0);
    endtask

    task automatic t_long;
        lookup(1'b1, 4'd0, 1'b1, 1'b1, K_OK, "R9 bypass no-access ok");
        lookup(1'b1, 4'd0, 1'b0, 1'b1, K_PERM, "R9 bypass no-access denied");
        lookup(1'b1, 4'd1, 1'b0, 1'b1, K_PERM, "R9 bypass manager denied");
        lookup(1'b1, 4'd1, 1'b0, 1'b0, K_OK, "R5 sec manager short");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset;
        t_codes;
        t_bank;
        t_lock;
        t_priv;
        t_long;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule